// File: doc/BRIEF.md
# Residual Harmonic Feature Extractor

This block turns three-phase voltage and current samples into six features for a downstream fault classifier. The features are the 2nd and 3rd harmonic magnitudes of the residual current and voltage, and the apparent impedance at each of those harmonics. Samples arrive as 12-bit two's-complement words at a nominal 1 kHz, which gives 20 samples per 50 Hz cycle. The frequency is fixed at that value and is not tracked. The block first adds the three phases of each quantity to form the residual signals. It then keeps a sliding one-cycle discrete Fourier transform, evaluated only at bins 2 and 3.

The DFT is updated once per sample, in a single cycle. The new residual sample enters and the sample from exactly one cycle earlier leaves, each weighted by the same fixed-point twiddle factor. Because of this the accumulators always hold the exact integer sum over the last 20 samples. Each magnitude is estimated without a square root. Each impedance is a fixed-point quotient formed by a bit-serial divider. A single feature-valid pulse marks the moment when all six words belong to the newest window.

Top module: `hd_residual_dft`

## Requirements
- R1: The residual current is ia_i+ib_i+ic_i and the residual voltage is va_i+vb_i+vc_i, each taken as a signed 14-bit sum of the sign-extended 12-bit inputs.
- R2: While rst_ni is low and after reset, feat_valid_o is 0 and all six feature outputs are 0. Every stored sample is cleared to zero.
- R3: feat_valid_o never rises for the first 19 samples after reset. The 20th sample is the first whose result is flagged.
- R4: Let s count accepted samples from 0 after reset, and let j=(k*s) mod 20 for bin k in {2,3}. The residual sample x enters the real sum with weight C(j)=round(1024*cos(2*pi*j/20)) and the imaginary sum with weight -S(j)=-round(1024*sin(2*pi*j/20)). The sums cover the last 20 samples, and slots not yet written count as zero.
- R5: Each magnitude output equals (max(|re|,|im|) + floor(min(|re|,|im|)/2)) >> 12. Outputs are ordered i2, i3, v2, v3.
- R6: The impedance output for bin k is floor(v_k_mag*32 / i_k_mag), a value with 5 fractional bits, saturated to 65535.
- R7: If i_k_mag is below 4, the impedance for bin k is 65535 whatever the voltage.
- R8: feat_valid_o is a one-cycle pulse. It is high after the 22nd clock edge that follows the edge capturing smp_valid_i, and all six outputs hold the values for that sample.
- R9: A sample accepted before the previous result is flagged cancels that result. Only one pulse follows, timed from the newer sample and carrying its window.
- R10: Input words are used only on edges where smp_valid_i is high. Values presented at other times have no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | One-cycle strobe marking a new sample set |
| va_i | input | 12 | Phase A voltage sample |
| vb_i | input | 12 | Phase B voltage sample |
| vc_i | input | 12 | Phase C voltage sample |
| ia_i | input | 12 | Phase A current sample |
| ib_i | input | 12 | Phase B current sample |
| ic_i | input | 12 | Phase C current sample |
| feat_valid_o | output | 1 | Pulse: the six features belong to the latest window |
| i2_mag_o | output | 16 | Residual current 2nd harmonic magnitude |
| i3_mag_o | output | 16 | Residual current 3rd harmonic magnitude |
| v2_mag_o | output | 16 | Residual voltage 2nd harmonic magnitude |
| v3_mag_o | output | 16 | Residual voltage 3rd harmonic magnitude |
| z2_o | output | 16 | 2nd harmonic impedance ratio |
| z3_o | output | 16 | 3rd harmonic impedance ratio |

## Verification
The function most likely to collide with another is the arrival of a new sample while the divider is still working on the previous window. The restart path and the window update then act in the same cycle. The bench provokes this by sending a second sample five cycles after the first. It then requires exactly one pulse, 22 edges after the second sample, carrying magnitudes and ratios computed from the window that includes both samples. A second overlap occurs once the window has wrapped: the oldest slot is read for subtraction and overwritten in the same edge. Every post-fill sample exercises this, and each is checked against sums the bench computes from its own copy of the last 20 residual values.

// File: rtl/hd_pkg.sv
package hd_pkg;
  localparam int WIN     = 20;
  localparam int PTR_W   = $clog2(WIN);
  localparam int TW_W    = 12;

  // round(1024*cos(2*pi*j/20))
  function automatic logic signed [TW_W-1:0] tw_cos(input logic [PTR_W-1:0] j);
    case (j)
      5'd0:  tw_cos = 12'sd1024;
      5'd1:  tw_cos = 12'sd974;
      5'd2:  tw_cos = 12'sd828;
      5'd3:  tw_cos = 12'sd602;
      5'd4:  tw_cos = 12'sd316;
      5'd5:  tw_cos = 12'sd0;
      5'd6:  tw_cos = -12'sd316;
      5'd7:  tw_cos = -12'sd602;
      5'd8:  tw_cos = -12'sd828;
      5'd9:  tw_cos = -12'sd974;
      5'd10: tw_cos = -12'sd1024;
      5'd11: tw_cos = -12'sd974;
      5'd12: tw_cos = -12'sd828;
      5'd13: tw_cos = -12'sd602;
      5'd14: tw_cos = -12'sd316;
      5'd15: tw_cos = 12'sd0;
      5'd16: tw_cos = 12'sd316;
      5'd17: tw_cos = 12'sd602;
      5'd18: tw_cos = 12'sd828;
      5'd19: tw_cos = 12'sd974;
      default: tw_cos = 12'sd0;
    endcase
  endfunction
endpackage

// File: rtl/hd_bin.sv
module hd_bin
  import hd_pkg::*;
#(
  parameter int K         = 2,
  parameter int DW        = 15,
  parameter int ACC_W     = 32,
  parameter int MAG_W     = 16,
  parameter int MAG_SHIFT = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] diff_i,
  input  logic [PTR_W-1:0]     ptr_i,
  output logic [MAG_W-1:0]     mag_o
);
  logic [7:0]             kp_w;
  logic [PTR_W-1:0]       cidx_w, sidx_w;
  logic signed [TW_W-1:0] cos_w, sin_w;
  logic signed [ACC_W-1:0] pc_w, ps_w, re_q, im_q;
  logic [ACC_W-1:0]       are_w, aim_w, mx_w, mn_w, sum_w, sh_w;

  assign kp_w   = 8'(K) * 8'(ptr_i);
  assign cidx_w = PTR_W'(kp_w % 8'(WIN));
  // sin(theta) = cos(theta - quarter turn)
  assign sidx_w = PTR_W'((6'(cidx_w) + 6'(WIN - WIN/4)) % 6'(WIN));
  assign cos_w  = tw_cos(cidx_w);
  assign sin_w  = tw_cos(sidx_w);
  assign pc_w   = $signed(ACC_W'(diff_i)) * $signed(ACC_W'(cos_w));
  assign ps_w   = $signed(ACC_W'(diff_i)) * $signed(ACC_W'(sin_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q <= '0;
      im_q <= '0;
    end else if (en_i) begin
      re_q <= re_q + pc_w;
      im_q <= im_q - ps_w;
    end
  end

  assign are_w = re_q[ACC_W-1] ? ACC_W'(-re_q) : ACC_W'(re_q);
  assign aim_w = im_q[ACC_W-1] ? ACC_W'(-im_q) : ACC_W'(im_q);
  assign mx_w  = (are_w > aim_w) ? are_w : aim_w;
  assign mn_w  = (are_w > aim_w) ? aim_w : are_w;
  assign sum_w = mx_w + (mn_w >> 1);
  assign sh_w  = sum_w >> MAG_SHIFT;
  assign mag_o = sh_w[MAG_W-1:0];
endmodule

// File: rtl/hd_div.sv
module hd_div #(
  parameter int NW = 21,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic [NW-1:0] quo_o,
  output logic          done_o
);
  localparam int CW = $clog2(NW + 1);

  logic [DW:0]   rem_q, rem_sh_w;
  logic [NW-1:0] q_q;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, ge_w;

  assign rem_sh_w = {rem_q[DW-1:0], q_q[NW-1]};
  assign ge_w     = rem_sh_w >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      q_q    <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        // restart abandons any division in flight
        rem_q  <= '0;
        q_q    <= num_i;
        den_q  <= den_i;
        cnt_q  <= CW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= ge_w ? (rem_sh_w - {1'b0, den_q}) : rem_sh_w;
        q_q    <= {q_q[NW-2:0], ge_w};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o  = q_q;
  assign done_o = done_q;

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q && !done_o);
  assert_done_after_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_q));
endmodule

// File: rtl/hd_residual_dft.sv
module hd_residual_dft
  import hd_pkg::*;
#(
  parameter int SW        = 12,
  parameter int ACC_W     = 32,
  parameter int MAG_W     = 16,
  parameter int MAG_SHIFT = 12,
  parameter int ZF        = 5,
  parameter int I_FLOOR   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SW-1:0]    va_i,
  input  logic [SW-1:0]    vb_i,
  input  logic [SW-1:0]    vc_i,
  input  logic [SW-1:0]    ia_i,
  input  logic [SW-1:0]    ib_i,
  input  logic [SW-1:0]    ic_i,
  output logic             feat_valid_o,
  output logic [MAG_W-1:0] i2_mag_o,
  output logic [MAG_W-1:0] i3_mag_o,
  output logic [MAG_W-1:0] v2_mag_o,
  output logic [MAG_W-1:0] v3_mag_o,
  output logic [MAG_W-1:0] z2_o,
  output logic [MAG_W-1:0] z3_o
);
  localparam int RW   = SW + 2;
  localparam int NW   = MAG_W + ZF;
  localparam int FC_W = $clog2(WIN + 1);

  logic signed [RW-1:0] ir_w, vr_w;
  logic signed [RW:0]   di_w, dv_w;
  logic signed [RW-1:0] ibuf_q [WIN];
  logic signed [RW-1:0] vbuf_q [WIN];
  logic [PTR_W-1:0]     ptr_q;
  logic [FC_W-1:0]      fill_q;
  logic                 st_q;
  logic [1:0]           done_v;
  logic [MAG_W-1:0]     z_v [2];

  assign ir_w = RW'($signed(ia_i)) + RW'($signed(ib_i)) + RW'($signed(ic_i));
  assign vr_w = RW'($signed(va_i)) + RW'($signed(vb_i)) + RW'($signed(vc_i));
  // oldest slot leaves as the new sample takes its place
  assign di_w = (RW+1)'(ir_w) - (RW+1)'(ibuf_q[ptr_q]);
  assign dv_w = (RW+1)'(vr_w) - (RW+1)'(vbuf_q[ptr_q]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < WIN; n++) begin
        ibuf_q[n] <= '0;
        vbuf_q[n] <= '0;
      end
      ptr_q  <= '0;
      fill_q <= '0;
      st_q   <= 1'b0;
    end else begin
      st_q <= smp_valid_i;
      if (smp_valid_i) begin
        ibuf_q[ptr_q] <= ir_w;
        vbuf_q[ptr_q] <= vr_w;
        ptr_q  <= (ptr_q == PTR_W'(WIN - 1)) ? '0 : ptr_q + 1'b1;
        if (fill_q != FC_W'(WIN)) fill_q <= fill_q + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bin
    logic [MAG_W-1:0] imag_w, vmag_w, im_q, vm_q;
    logic [NW-1:0]    quo_w;
    logic             floor_q, done_w;

    hd_bin #(.K(b + 2), .DW(RW + 1), .ACC_W(ACC_W), .MAG_W(MAG_W), .MAG_SHIFT(MAG_SHIFT))
      u_ibin (.clk_i(clk_i), .rst_ni(rst_ni), .en_i(smp_valid_i), .diff_i(di_w),
              .ptr_i(ptr_q), .mag_o(imag_w));
    hd_bin #(.K(b + 2), .DW(RW + 1), .ACC_W(ACC_W), .MAG_W(MAG_W), .MAG_SHIFT(MAG_SHIFT))
      u_vbin (.clk_i(clk_i), .rst_ni(rst_ni), .en_i(smp_valid_i), .diff_i(dv_w),
              .ptr_i(ptr_q), .mag_o(vmag_w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        im_q    <= '0;
        vm_q    <= '0;
        floor_q <= 1'b0;
      end else if (st_q) begin
        im_q    <= imag_w;
        vm_q    <= vmag_w;
        floor_q <= imag_w < MAG_W'(I_FLOOR);
      end
    end

    hd_div #(.NW(NW), .DW(MAG_W)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(st_q),
      .num_i({vmag_w, ZF'(0)}), .den_i(imag_w),
      .quo_o(quo_w), .done_o(done_w));

    assign done_v[b] = done_w;
    assign z_v[b] = (floor_q || (|quo_w[NW-1:MAG_W])) ? '1 : quo_w[MAG_W-1:0];
  end

  assign feat_valid_o = (&done_v) && (fill_q == FC_W'(WIN));
  assign i2_mag_o = g_bin[0].im_q;
  assign i3_mag_o = g_bin[1].im_q;
  assign v2_mag_o = g_bin[0].vm_q;
  assign v3_mag_o = g_bin[1].vm_q;
  assign z2_o     = z_v[0];
  assign z3_o     = z_v[1];

  assert_ptr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q < PTR_W'(WIN));
  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_valid_o |=> !feat_valid_o);
  assert_mag_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_q |=> $stable(i2_mag_o) && $stable(v3_mag_o));
  assert_floor_z2_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feat_valid_o && i2_mag_o < MAG_W'(I_FLOOR)) |-> z2_o == '1);
  assert_floor_z3_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feat_valid_o && i3_mag_o < MAG_W'(I_FLOOR)) |-> z3_o == '1);
endmodule

// File: tb/sim_hd_residual_dft.sv
`timescale 1ns/1ps
module sim_hd_residual_dft;
  localparam int LAT = 22;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [11:0] va = '0, vb = '0, vc = '0, ia = '0, ib = '0, ic = '0;
  logic fv;
  logic [15:0] i2, i3, v2, v3, z2, z3;

  int nchk = 0, nfail = 0;
  int hi[20], hv[20];
  int nsmp = 0;
  int ex[6];

  always #2 clk = ~clk;

  hd_residual_dft u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid),
    .va_i(va), .vb_i(vb), .vc_i(vc), .ia_i(ia), .ib_i(ib), .ic_i(ic),
    .feat_valid_o(fv), .i2_mag_o(i2), .i3_mag_o(i3), .v2_mag_o(v2),
    .v3_mag_o(v3), .z2_o(z2), .z3_o(z3));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? int'($floor(x + 0.5)) : -int'($floor(-x + 0.5));
  endfunction

  function automatic int clamp(input int x);
    return (x > 2047) ? 2047 : ((x < -2048) ? -2048 : x);
  endfunction

  // R4: bench-side twiddles from the stated rounding rule
  function automatic int twc(input int j);
    return rnd(1024.0 * $cos(2.0 * PI * j / 20.0));
  endfunction
  function automatic int tws(input int j);
    return rnd(1024.0 * $sin(2.0 * PI * j / 20.0));
  endfunction

  // R4, R5: exact window sums, then max + min/2 estimate
  function automatic int bin_mag(input bit volt, input int k);
    longint re = 0, im = 0, ar, ai, mx, mn;
    for (int m = 0; m < 20; m++) begin
      longint x = volt ? hv[m] : hi[m];
      re += x * twc((k * m) % 20);
      im -= x * tws((k * m) % 20);
    end
    ar = (re < 0) ? -re : re;
    ai = (im < 0) ? -im : im;
    mx = (ar > ai) ? ar : ai;
    mn = (ar > ai) ? ai : ar;
    return int'((mx + mn / 2) >>> 12);
  endfunction

  // R6, R7
  function automatic int exp_z(input int vm, input int im);
    longint q;
    if (im < 4) return 65535;
    q = (longint'(vm) * 32) / im;
    return (q > 65535) ? 65535 : int'(q);
  endfunction

  function automatic int hcos(input real amp, input int h, input int n, input real ph);
    return rnd(amp * $cos(2.0 * PI * h * n / 20.0 + ph));
  endfunction

  task automatic put(input int p, input int n);
    int a, b, c, x, y, z;
    case (p)
      0: begin
        x = hcos(600.0, 2, n, 0.0); y = x; z = x;
        a = hcos(1500.0, 3, n, 0.3); b = a; c = a;
      end
      1: begin
        a = hcos(1800.0, 1, n, 0.0) + hcos(200.0, 3, n, 0.0);
        b = hcos(1800.0, 1, n, -2.0 * PI / 3.0) + hcos(200.0, 3, n, 0.0);
        c = hcos(1800.0, 1, n, 2.0 * PI / 3.0) + hcos(200.0, 3, n, 0.0);
        x = hcos(1000.0, 1, n, 0.0) + hcos(100.0, 2, n, 0.7) + hcos(150.0, 3, n, 1.0);
        y = hcos(1000.0, 1, n, -2.0 * PI / 3.0) + hcos(150.0, 3, n, 1.0);
        z = hcos(1000.0, 1, n, 2.0 * PI / 3.0) + hcos(150.0, 3, n, 1.0);
      end
      2: begin
        a = (n % 2) ? 2047 : -2048; b = a; c = a; x = a; y = a; z = a;
      end
      3: begin
        x = 0; y = 0; z = 0;
        a = hcos(1200.0, 3, n, 0.0); b = a; c = a;
      end
      4: begin
        x = hcos(1.0, 2, n, 0.0); y = 0; z = 0;
        a = hcos(2047.0, 2, n, 0.5); b = a; c = a;
      end
      default: begin
        x = hcos(2.0, 2, n, 0.0); y = 0; z = 0;
        a = hcos(2047.0, 2, n, 0.5); b = a; c = a;
      end
    endcase
    a = clamp(a); b = clamp(b); c = clamp(c);
    x = clamp(x); y = clamp(y); z = clamp(z);
    va = 12'(a); vb = 12'(b); vc = 12'(c);
    ia = 12'(x); ib = 12'(y); ic = 12'(z);
    smp_valid = 1'b1;
    // R1: residual is the plain sum of phases
    hv[nsmp % 20] = a + b + c;
    hi[nsmp % 20] = x + y + z;
    nsmp++;
  endtask

  task automatic calc_exp();
    ex[0] = bin_mag(1'b0, 2);
    ex[1] = bin_mag(1'b0, 3);
    ex[2] = bin_mag(1'b1, 2);
    ex[3] = bin_mag(1'b1, 3);
    ex[4] = exp_z(ex[2], ex[0]);
    ex[5] = exp_z(ex[3], ex[1]);
  endtask

  task automatic run_one(input int p, input int n, input bit bb, input int pb, input int nb);
    int tgt, extra;
    bit full;
    tgt = bb ? LAT + 6 : LAT;
    extra = 0;
    @(negedge clk);
    put(p, n);
    calc_exp();
    full = (nsmp >= 20);
    for (int i = 0; i <= LAT + 10; i++) begin
      @(negedge clk);
      if (bb && i == 5) begin
        put(pb, nb);
        calc_exp();
        full = (nsmp >= 20);
      end else begin
        // R10: idle-time words must not reach any result
        smp_valid = 1'b0;
        va = 12'($urandom); vb = 12'($urandom); vc = 12'($urandom);
        ia = 12'($urandom); ib = 12'($urandom); ic = 12'($urandom);
      end
      if (i == tgt) begin
        if (full) begin
          chk(bb ? "R9 pulse after restart" : "R8 pulse timing", int'(fv), 1);
          if (fv) begin
            chk("R5 R1 i2_mag", int'(i2), ex[0]);
            chk("R5 R1 i3_mag", int'(i3), ex[1]);
            chk("R5 R1 v2_mag", int'(v2), ex[2]);
            chk("R5 R1 v3_mag", int'(v3), ex[3]);
            chk((ex[0] < 4) ? "R7 z2 floor" : "R6 z2 ratio", int'(z2), ex[4]);
            chk((ex[1] < 4) ? "R7 z3 floor" : "R6 z3 ratio", int'(z3), ex[5]);
          end
        end else begin
          chk("R3 no valid before window fills", int'(fv), 0);
        end
      end else if (fv) begin
        extra++;
      end
    end
    chk(bb ? "R9 no stale pulse" : "R8 single pulse", extra, 0);
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    for (int m = 0; m < 20; m++) begin hi[m] = 0; hv[m] = 0; end
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 valid in reset", int'(fv), 0);
    chk("R2 mags in reset", int'(i2 | i3 | v2 | v3), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ratios after reset", int'(z2 | z3), 0);
    chk("R2 valid after reset", int'(fv), 0);
    for (int n = 0; n < 25; n++) run_one(0, n, 1'b0, 0, 0);
    for (int n = 0; n < 25; n++) run_one(1, n, 1'b0, 0, 0);
    for (int n = 0; n < 22; n++) run_one(2, n, 1'b0, 0, 0);
    for (int n = 0; n < 22; n++) run_one(3, n, 1'b0, 0, 0);
    for (int n = 0; n < 22; n++) run_one(4, n, 1'b0, 0, 0);
    for (int n = 0; n < 22; n++) run_one(5, n, 1'b0, 0, 0);
    // R9: second sample lands while the first division runs
    for (int n = 0; n < 6; n++) run_one(1, 2 * n, 1'b1, 0, 2 * n + 1);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule